// File: doc/BRIEF.md
# Converter Sample Queue with Interrupt Flags

This block sits between an analog-to-digital converter and the system bus. Every completed conversion result arrives as a one-cycle write strobe and is queued without any software action. A CPU or DMA requester drains the queue with a one-cycle read strobe. It can poll the fill level to find out when data is waiting.

Around the queue the block keeps five sticky status flags. Two report errors: a sample that arrived when no space was left, and a read request made when nothing was stored. One is a watermark flag whose level is picked from a small menu. Two record positive and negative saturation events signalled by the converter. Each flag has a mask bit and a write-one-to-clear strobe. A single interrupt line is the OR of the unmasked flags.

Top module: `sample_fifo_irq`

## Requirements
- R1: After reset, fill_level is 0, flag_status is 0, irq is 0 and rd_data is 0.
- R2: Samples leave in arrival order. A read strobe on a non-empty queue removes the oldest sample, and that sample appears on rd_data one clock later. rd_data keeps its value until the next accepted read.
- R3: fill_level gives the number of stored samples, from 0 to DEPTH (0 to 32 by default). It changes one clock after an accepted write or read.
- R4: A write strobe while the queue is full and no read strobe is present sets flag_status bit 0 (overrun). The sample is dropped and fill_level and the stored contents stay unchanged.
- R5: A read strobe while the queue is empty sets flag_status bit 1 (underrun). rd_data keeps its previous value and fill_level stays 0.
- R6: Write and read strobes together on a full queue form a normal transfer. The oldest sample is returned, the new one is stored, fill_level stays at DEPTH and bit 0 is not set.
- R7: thr_sel picks the watermark level: 0 gives 1 entry, 1 gives 4, 2 gives 8 and 3 gives 16. flag_status bit 2 is set one clock after fill_level is at or above the selected level.
- R8: A pulse on sat_pos_evt sets flag_status bit 3. A pulse on sat_neg_evt sets flag_status bit 4.
- R9: Every flag is sticky and sets whatever its mask bit says. A 1 on flag_clr bit i clears flag bit i on the next clock. If a set and a clear reach the same bit in the same cycle, the set wins.
- R10: irq is high exactly when some flag_status bit is set whose flag_mask bit is 0. A mask bit of 1 suppresses that flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_valid | input | 1 | Conversion-complete write strobe |
| wr_data | input | DATA_W | Conversion result to store |
| rd_req | input | 1 | Read strobe from CPU or DMA |
| rd_data | output | DATA_W | Sample returned by the last accepted read |
| fill_level | output | $clog2(DEPTH+1) | Number of stored samples |
| thr_sel | input | 2 | Watermark level select |
| sat_pos_evt | input | 1 | Positive saturation event pulse |
| sat_neg_evt | input | 1 | Negative saturation event pulse |
| flag_mask | input | 5 | Per-flag interrupt suppress bits |
| flag_clr | input | 5 | Per-flag write-one-to-clear strobes |
| flag_status | output | 5 | Sticky flags: 0 overrun, 1 underrun, 2 watermark, 3 positive saturation, 4 negative saturation |
| irq | output | 1 | Combined interrupt |

## Verification
The bench uses the default parameters: 32 entries of 26 bits. At this size it can fill the queue completely, check every fill level, overflow it and drain it to empty and beyond. It also steps each of the four watermark levels entry by entry, from empty up to 17 entries. The full-queue transfer and the overrun and underrun boundaries all come up naturally. Each flag is then tested on its own for stickiness, for set winning over clear, and for the effect of its mask on irq.

// File: rtl/sfq_pkg.sv
package sfq_pkg;

  localparam int NUM_FLAGS = 5;
  localparam int FLG_OVR   = 0;
  localparam int FLG_UDR   = 1;
  localparam int FLG_THR   = 2;
  localparam int FLG_PSAT  = 3;
  localparam int FLG_NSAT  = 4;

  // Watermark menu: 1, then doubling from 4; clipped to the queue depth.
  function automatic int thr_level(input logic [1:0] sel, input int depth);
    int lvl;
    if (sel == 2'd0) lvl = 1;
    else             lvl = 2 << sel;
    if (lvl > depth) lvl = depth;
    return lvl;
  endfunction

endpackage

// File: rtl/sfq_rst_sync.sv
module sfq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];

endmodule

// File: rtl/sfq_store.sv
module sfq_store #(
  parameter  int DATA_W = 26,
  parameter  int DEPTH  = 32,
  localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_en,
  input  logic              pop_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  count
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp_q, wp_d, rp_q, rp_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] rdat_q, rdat_d;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // Next-state
  always_comb begin
    wp_d   = wp_q;
    rp_d   = rp_q;
    cnt_d  = cnt_q;
    rdat_d = rdat_q;
    if (push_en) wp_d = ptr_inc(wp_q);
    if (pop_en) begin
      rp_d   = ptr_inc(rp_q);
      rdat_d = mem[rp_q];
    end
    case ({push_en, pop_en})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      rp_q   <= '0;
      cnt_q  <= '0;
      rdat_q <= '0;
    end else begin
      wp_q   <= wp_d;
      rp_q   <= rp_d;
      cnt_q  <= cnt_d;
      rdat_q <= rdat_d;
    end
  end

  // Storage array, written only when enabled
  always_ff @(posedge clk) begin
    if (push_en) mem[wp_q] <= wr_data;
  end

  assign rd_data = rdat_q;
  assign count   = cnt_q;

endmodule

// File: rtl/sfq_flags.sv
module sfq_flags #(
  parameter int NF = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_evt,
  input  logic [NF-1:0] clr,
  input  logic [NF-1:0] mask,
  output logic [NF-1:0] status,
  output logic          irq
);

  logic [NF-1:0] flag_q, flag_d;

  for (genvar i = 0; i < NF; i++) begin : g_bit
    // set dominates clear
    assign flag_d[i] = set_evt[i] | (flag_q[i] & ~clr[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign status = flag_q;
  assign irq    = |(flag_q & ~mask);

endmodule

// File: rtl/sample_fifo_irq.sv
module sample_fifo_irq
  import sfq_pkg::*;
#(
  parameter  int DATA_W = 26,
  parameter  int DEPTH  = 32,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_valid,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 rd_req,
  output logic [DATA_W-1:0]    rd_data,
  output logic [CNT_W-1:0]     fill_level,
  input  logic [1:0]           thr_sel,
  input  logic                 sat_pos_evt,
  input  logic                 sat_neg_evt,
  input  logic [NUM_FLAGS-1:0] flag_mask,
  input  logic [NUM_FLAGS-1:0] flag_clr,
  output logic [NUM_FLAGS-1:0] flag_status,
  output logic                 irq
);

  logic                 rst_sn;
  logic [CNT_W-1:0]     count;
  logic                 full, empty, pop_ok, push_ok;
  logic [CNT_W-1:0]     thr_lvl;
  logic [NUM_FLAGS-1:0] evt;

  sfq_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign pop_ok  = rd_req & ~empty;
  assign push_ok = wr_valid & (~full | pop_ok);
  assign thr_lvl = CNT_W'(thr_level(thr_sel, DEPTH));

  always_comb begin
    evt           = '0;
    evt[FLG_OVR]  = wr_valid & full & ~rd_req;
    evt[FLG_UDR]  = rd_req & empty;
    evt[FLG_THR]  = (count >= thr_lvl);
    evt[FLG_PSAT] = sat_pos_evt;
    evt[FLG_NSAT] = sat_neg_evt;
  end

  sfq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_sn),
    .push_en (push_ok),
    .pop_en  (pop_ok),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .count   (count)
  );

  sfq_flags #(.NF(NUM_FLAGS)) u_flags (
    .clk     (clk),
    .rst_n   (rst_sn),
    .set_evt (evt),
    .clr     (flag_clr),
    .mask    (flag_mask),
    .status  (flag_status),
    .irq     (irq)
  );

  assign fill_level = count;

endmodule

// File: rtl/sfq_checker.sv
module sfq_checker #(
  parameter  int DATA_W = 26,
  parameter  int DEPTH  = 32,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              rd_req,
  input logic [DATA_W-1:0] rd_data,
  input logic [CNT_W-1:0]  fill_level,
  input logic              sat_pos_evt,
  input logic              sat_neg_evt,
  input logic [4:0]        flag_clr,
  input logic [4:0]        flag_status,
  input logic              irq
);

  p_fill_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= CNT_W'(DEPTH));

  p_overrun_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !rd_req && fill_level == CNT_W'(DEPTH) |=> flag_status[0]);

  p_overrun_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !rd_req && fill_level == CNT_W'(DEPTH) |=> fill_level == CNT_W'(DEPTH));

  p_underrun_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && fill_level == '0 |=> flag_status[1]);

  p_underrun_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !wr_valid && fill_level == '0 |=> $stable(rd_data) && fill_level == '0);

  p_full_xfer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && rd_req && fill_level == CNT_W'(DEPTH)
    |=> fill_level == CNT_W'(DEPTH) && !$rose(flag_status[0]));

  p_sat_pos_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sat_pos_evt |=> flag_status[3]);

  p_sat_neg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sat_neg_evt |=> flag_status[4]);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_status[4] && !flag_clr[4] |=> flag_status[4]);

  p_irq_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag_status != 5'b0);

endmodule

bind sample_fifo_irq sfq_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sn),
  .wr_valid    (wr_valid),
  .rd_req      (rd_req),
  .rd_data     (rd_data),
  .fill_level  (fill_level),
  .sat_pos_evt (sat_pos_evt),
  .sat_neg_evt (sat_neg_evt),
  .flag_clr    (flag_clr),
  .flag_status (flag_status),
  .irq         (irq)
);

// File: tb/sample_fifo_irq_bench.sv
`timescale 1ns/1ps
module sample_fifo_irq_bench;

  localparam int DW = 26;
  localparam int DP = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_valid, rd_req, sat_pos_evt, sat_neg_evt;
  logic [DW-1:0] wr_data, rd_data;
  logic [5:0]    fill_level;
  logic [1:0]    thr_sel;
  logic [4:0]    flag_mask, flag_clr, flag_status;
  logic          irq;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;
  logic [DW-1:0] model [$];
  logic [DW-1:0] exp_v, last_rd;

  always #2 clk = ~clk;

  sample_fifo_irq u_sample_fifo_irq (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .rd_req(rd_req), .rd_data(rd_data), .fill_level(fill_level),
    .thr_sel(thr_sel), .sat_pos_evt(sat_pos_evt), .sat_neg_evt(sat_neg_evt),
    .flag_mask(flag_mask), .flag_clr(flag_clr), .flag_status(flag_status),
    .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int i);
    return DW'((i * 12345 + 77) ^ (i << 19));
  endfunction

  // one cycle of stimulus, driven after a falling edge, released after the next
  task automatic cyc(input bit wr, input logic [DW-1:0] d, input bit rd,
                     input logic [4:0] clr, input bit pos, input bit neg);
    wr_valid = wr; wr_data = d; rd_req = rd; flag_clr = clr;
    sat_pos_evt = pos; sat_neg_evt = neg;
    @(negedge clk);
    wr_valid = 0; rd_req = 0; flag_clr = '0; sat_pos_evt = 0; sat_neg_evt = 0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic push(input logic [DW-1:0] d);
    cyc(1, d, 0, '0, 0, 0);
    if (model.size() < DP) model.push_back(d);
    idle();
  endtask

  task automatic pop_chk();
    cyc(0, '0, 1, '0, 0, 0);
    exp_v = model.pop_front();
    chk(rd_data == exp_v, "R2 oldest sample out", rd_data, exp_v);
    idle();
    chk(fill_level == model.size(), "R3 fill after read", fill_level, model.size());
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wr_valid = 0; rd_req = 0; wr_data = '0; sat_pos_evt = 0;
    sat_neg_evt = 0; flag_mask = '0; flag_clr = '0; thr_sel = 2'd2;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(fill_level == 0, "R1 fill", fill_level, 0);
    chk(flag_status == 0, "R1 flags", flag_status, 0);
    chk(irq == 0, "R1 irq", irq, 0);
    chk(rd_data == 0, "R1 rd_data", rd_data, 0);

    // R3 / R7 fill sweep at watermark 8
    for (int i = 0; i < DP; i++) begin
      push(pat(i));
      chk(fill_level == i + 1, "R3 fill after write", fill_level, i + 1);
      chk(flag_status[2] == (i + 1 >= 8), "R7 watermark level 8", flag_status[2], (i + 1 >= 8));
    end

    // R4 overrun
    chk(flag_status[0] == 0, "R4 no overrun before", flag_status[0], 0);
    push(26'h3ABCDE);
    chk(flag_status[0] == 1, "R4 overrun flag", flag_status[0], 1);
    chk(fill_level == DP, "R4 fill unchanged", fill_level, DP);

    // R6 simultaneous transfer on full
    cyc(0, '0, 0, 5'h1f, 0, 0);
    idle();
    cyc(1, pat(100), 1, '0, 0, 0);
    exp_v = model.pop_front();
    model.push_back(pat(100));
    chk(rd_data == exp_v, "R6 read on full", rd_data, exp_v);
    idle();
    chk(fill_level == DP, "R6 fill stays full", fill_level, DP);
    chk(flag_status[0] == 0, "R6 no overrun", flag_status[0], 0);

    // R2 drain in order (overrun sample must not appear)
    for (int i = 0; i < DP; i++) pop_chk();

    // R5 underrun
    last_rd = rd_data;
    cyc(0, '0, 1, '0, 0, 0);
    idle();
    chk(flag_status[1] == 1, "R5 underrun flag", flag_status[1], 1);
    chk(rd_data == last_rd, "R5 rd_data held", rd_data, last_rd);
    chk(fill_level == 0, "R5 fill stays 0", fill_level, 0);

    // R9 set wins over clear on underrun bit
    cyc(0, '0, 1, 5'b00010, 0, 0);
    idle();
    chk(flag_status[1] == 1, "R9 set beats clear", flag_status[1], 1);

    // R7 every watermark level
    for (int s = 0; s < 4; s++) begin
      int lvl;
      lvl = (s == 0) ? 1 : (2 << s);
      thr_sel = 2'(s);
      cyc(0, '0, 0, 5'h1f, 0, 0);
      idle();
      chk(flag_status == 0, "R9 clear all", flag_status, 0);
      for (int n = 1; n <= 17; n++) begin
        push(pat(200 + s * 20 + n));
        chk(flag_status[2] == (n >= lvl), "R7 watermark select", flag_status[2], (n >= lvl));
      end
      for (int n = 0; n < 17; n++) pop_chk();
    end
    cyc(0, '0, 0, 5'h1f, 0, 0);
    idle();

    // R8 saturation events
    cyc(0, '0, 0, '0, 1, 0);
    idle();
    chk(flag_status == 5'b01000, "R8 positive saturation", flag_status, 5'b01000);
    cyc(0, '0, 0, '0, 0, 1);
    idle();
    chk(flag_status == 5'b11000, "R8 negative saturation", flag_status, 5'b11000);

    // R9 sticky, set wins, individual clear
    repeat (3) idle();
    chk(flag_status == 5'b11000, "R9 sticky", flag_status, 5'b11000);
    cyc(0, '0, 0, 5'b01000, 1, 0);
    idle();
    chk(flag_status[3] == 1, "R9 pos set beats clear", flag_status[3], 1);
    cyc(0, '0, 0, 5'b01000, 0, 0);
    idle();
    chk(flag_status == 5'b10000, "R9 single clear", flag_status, 5'b10000);

    // R10 masking
    chk(irq == 1, "R10 irq unmasked", irq, 1);
    flag_mask = 5'b10000;
    idle();
    chk(irq == 0, "R10 irq masked", irq, 0);
    flag_mask = 5'h1f;
    cyc(0, '0, 0, '0, 1, 0);
    idle();
    chk(flag_status[3] == 1, "R9 sets while masked", flag_status[3], 1);
    chk(irq == 0, "R10 all masked", irq, 0);
    flag_mask = 5'b10111;
    idle();
    chk(irq == 1, "R10 one unmasked", irq, 1);
    cyc(0, '0, 0, 5'h1f, 0, 0);
    idle();
    chk(flag_status == 0, "R9 clear all end", flag_status, 0);
    chk(irq == 0, "R10 irq idle", irq, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule